// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small 16-bit processor built around a single accumulator. Program and data share one memory. The core reaches that memory through one port, which carries a 12-bit address, separate write and read data buses, and read and write strobes. Every memory access completes within the clock cycle that issues it. All state in the core changes on the falling clock edge. An instruction word holds a 4-bit opcode in bits 15:12 and a 12-bit address in bits 11:0. The core uses the address field either as an operand location or as a jump target.

The sequencer has one state bit, which gives two states. In `ST_FETCH` the core reads the word at the program counter into the instruction register, advances the program counter, and always moves to `ST_EXEC`. In `ST_EXEC` the core carries out the instruction held in the instruction register, and there are three transitions. An operand instruction (load, store, add, subtract) makes its memory access and moves to `ST_FETCH`. A jump fetches its successor in the same cycle and stays in `ST_EXEC`. A stop or reserved code also stays in `ST_EXEC`, where it holds everything and raises `halted`. As a result, each instruction takes as many cycles as it makes memory accesses.

Asynchronous reset sets the program counter to 0 and the accumulator to 0 and enters `ST_FETCH`. The first instruction is therefore fetched from address 0.

Top module: `acc_core`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, the core drives a read at address 0 and `halted` is low.
- R2: Opcode 0 (bits 15:12) loads the accumulator from the memory word at the address field (bits 11:0).
- R3: Opcode 1 writes the accumulator to the address field location. `mem_wr` is high and `mem_wdata` equals the accumulator. The next cycle is a fetch.
- R4: Opcode 2 adds the memory word to the accumulator, modulo 2^16.
- R5: Opcode 3 subtracts the memory word from the accumulator, modulo 2^16.
- R6: Opcode 4 always jumps. In the same cycle it reads the instruction at the target, and execution continues at target+1.
- R7: Opcode 5 jumps when bit 15 of the accumulator is 0. Otherwise execution continues at the next sequential address.
- R8: Opcode 6 jumps when the accumulator is non-zero. Otherwise execution continues sequentially.
- R9: Opcode 7, and every code from 8 to 15, raises `halted`. Until reset, `halted` stays high, no strobe is issued, the address stays frozen and memory is not changed.
- R10: Counting from reset release to `halted`, the cycle count is 1 for the first fetch, plus 2 per operand instruction, plus 1 per jump.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its falling edge |
| rst | input | 1 | Asynchronous reset, active high |
| mem_addr | output | 12 | Memory address: the program counter when fetching, the address field when accessing an operand or taking a jump |
| mem_wdata | output | 16 | Store data (the accumulator) |
| mem_rdata | input | 16 | Read data, valid within the same cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High while a stop or reserved instruction is held |

## Verification
The accumulator and program counter cannot be seen at the ports, so it is hard to observe which branch a conditional jump took. The stimulus solves this with small programs. Each program loads a chosen value and jumps on it. The two paths then store different markers to the same location, and the bench reads that location back from its memory model. Jump outcomes are swept over sign and zero boundary values for every jump opcode. Load, store, add and subtract are swept over all pairs of a boundary value set. Every stop and reserved code is run and then held for many cycles, to confirm that no access follows.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'd1;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'd2;
    localparam logic [OPC_W-1:0] OPC_SUB   = 4'd3;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 4'd4;
    localparam logic [OPC_W-1:0] OPC_JPOS  = 4'd5;
    localparam logic [OPC_W-1:0] OPC_JNZ   = 4'd6;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_EXEC  = 1'b1
    } state_t;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_SUB  = 2'd2
    } alu_op_t;

    typedef struct packed {
        logic    acc_en;
        logic    pc_en;
        logic    ir_en;
        logic    addr_from_ir;
        logic    rd;
        logic    wr;
        logic    halt;
        alu_op_t alu_op;
    } ctrl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_t           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = b;
        endcase
    end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_core_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             acc_neg,
    input  logic             acc_zero,
    output state_t           state,
    output ctrl_t            ctrl
);

    state_t state_nx;

    always_ff @(negedge clk or posedge rst) begin
        if (rst) state <= ST_FETCH;
        else     state <= state_nx;
    end

    always_comb begin
        logic taken;
        ctrl     = '0;
        ctrl.alu_op = ALU_PASS;
        state_nx = state;
        taken    = 1'b0;
        unique case (state)
            ST_FETCH: begin
                ctrl.rd    = 1'b1;
                ctrl.ir_en = 1'b1;
                ctrl.pc_en = 1'b1;
                state_nx   = ST_EXEC;
            end
            ST_EXEC: begin
                unique case (opcode)
                    OPC_LOAD, OPC_ADD, OPC_SUB: begin
                        ctrl.rd           = 1'b1;
                        ctrl.acc_en       = 1'b1;
                        ctrl.addr_from_ir = 1'b1;
                        ctrl.alu_op       = (opcode == OPC_ADD) ? ALU_ADD :
                                            (opcode == OPC_SUB) ? ALU_SUB : ALU_PASS;
                        state_nx          = ST_FETCH;
                    end
                    OPC_STORE: begin
                        ctrl.wr           = 1'b1;
                        ctrl.addr_from_ir = 1'b1;
                        state_nx          = ST_FETCH;
                    end
                    OPC_JUMP, OPC_JPOS, OPC_JNZ: begin
                        taken = (opcode == OPC_JUMP) ||
                                (opcode == OPC_JPOS && !acc_neg) ||
                                (opcode == OPC_JNZ  && !acc_zero);
                        ctrl.rd           = 1'b1;
                        ctrl.ir_en        = 1'b1;
                        ctrl.pc_en        = 1'b1;
                        ctrl.addr_from_ir = taken;
                        state_nx          = ST_EXEC;
                    end
                    default: begin
                        ctrl.halt = 1'b1;
                        state_nx  = ST_EXEC;
                    end
                endcase
            end
            default: state_nx = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [ADDR_W+OPC_W-1:0]   mem_wdata,
    input  logic [ADDR_W+OPC_W-1:0]   mem_rdata,
    output logic                      mem_rd,
    output logic                      mem_wr,
    output logic                      halted
);

    localparam int DATA_W = ADDR_W + OPC_W;

    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] alu_y;
    state_t            state;
    ctrl_t             ctrl;

    acc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opcode   (ir[DATA_W-1 -: OPC_W]),
        .acc_neg  (acc[DATA_W-1]),
        .acc_zero (acc == '0),
        .state    (state),
        .ctrl     (ctrl)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op (ctrl.alu_op),
        .a  (acc),
        .b  (mem_rdata),
        .y  (alu_y)
    );

    assign mem_addr  = ctrl.addr_from_ir ? ir[ADDR_W-1:0] : pc;
    assign mem_wdata = acc;
    assign mem_rd    = ctrl.rd;
    assign mem_wr    = ctrl.wr;
    assign halted    = ctrl.halt;

    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            pc  <= '0;
            acc <= '0;
            ir  <= '0;
        end else begin
            if (ctrl.pc_en)  pc  <= mem_addr + 1'b1;
            if (ctrl.ir_en)  ir  <= mem_rdata;
            if (ctrl.acc_en) acc <= alu_y;
        end
    end

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
    import acc_core_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              halted,
    input state_t            state
);

    a_r11_strobe_excl: assert property (@(negedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r9_halt_sticky: assert property (@(negedge clk) disable iff (rst)
        halted |=> (halted && !mem_rd && !mem_wr && $stable(mem_addr)));

    a_r3_store_then_fetch: assert property (@(negedge clk) disable iff (rst)
        mem_wr |=> (mem_rd && state == ST_FETCH));

    a_r10_fetch_then_exec: assert property (@(negedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (state == ST_EXEC));

    a_r1_fetch_reads: assert property (@(negedge clk) disable iff (rst)
        (state == ST_FETCH) |-> (mem_rd && !halted));

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .halted   (halted),
    .state    (state)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b1;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_rd;
    logic        mem_wr;
    logic        halted;

    logic [15:0] mem [0:255];
    int n_tests = 0;
    int n_fail  = 0;
    int strobe_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .halted    (halted)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(negedge clk) if (!rst && mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    always @(posedge clk) if (!rst && mem_rd && mem_wr) strobe_err++;

    function automatic logic [15:0] ins(input int op, input int a);
        return {op[3:0], a[11:0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic run_prog(output int cyc);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #1;
        check(mem_rd && !mem_wr && mem_addr == 12'h000 && !halted, "R1",
              {mem_rd, mem_wr, halted, mem_addr}, 16'h4000);
        cyc = 0;
        while (!halted && cyc < 500) begin
            @(posedge clk);
            #1;
            cyc++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int vals [8] = '{0, 1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hAAAA, 5};
        int cyc;

        // R2 R3 R4 R5 R10: arithmetic sweep over all pairs
        foreach (vals[i]) begin
            foreach (vals[j]) begin
                clear_mem();
                mem[0] = ins(0, 100);
                mem[1] = ins(1, 104);
                mem[2] = ins(2, 101);
                mem[3] = ins(1, 102);
                mem[4] = ins(0, 100);
                mem[5] = ins(3, 101);
                mem[6] = ins(1, 103);
                mem[7] = ins(7, 0);
                mem[100] = vals[i][15:0];
                mem[101] = vals[j][15:0];
                run_prog(cyc);
                check(mem[104] == vals[i][15:0], "R2 R3 load/store", mem[104], vals[i][15:0]);
                check(mem[102] == 16'(vals[i] + vals[j]), "R4 add", mem[102], 16'(vals[i] + vals[j]));
                check(mem[103] == 16'(vals[i] - vals[j]), "R5 sub", mem[103], 16'(vals[i] - vals[j]));
                check(cyc == 15, "R10 cycles", cyc, 15);
            end
        end

        // R6 R7 R8: jump sweep
        for (int op = 4; op <= 6; op++) begin
            foreach (vals[i]) begin
                bit tk;
                logic [15:0] v;
                string tag;
                v   = vals[i][15:0];
                tk  = (op == 4) || (op == 5 && !v[15]) || (op == 6 && v != 0);
                tag = (op == 4) ? "R6 jump" : (op == 5) ? "R7 jump-if-positive" : "R8 jump-if-nonzero";
                clear_mem();
                mem[0] = ins(0, 100);
                mem[1] = ins(op, 5);
                mem[2] = ins(0, 101);
                mem[3] = ins(1, 103);
                mem[4] = ins(7, 0);
                mem[5] = ins(0, 102);
                mem[6] = ins(1, 103);
                mem[7] = ins(7, 0);
                mem[100] = v;
                mem[101] = 16'hAAAA;
                mem[102] = 16'h5555;
                run_prog(cyc);
                check(mem[103] == (tk ? 16'h5555 : 16'hAAAA), tag, mem[103], tk ? 16'h5555 : 16'hAAAA);
                check(cyc == 8, "R10 jump cycles", cyc, 8);
            end
        end

        // R9: stop and reserved codes
        for (int op = 7; op <= 15; op++) begin
            logic [11:0] a0;
            bit quiet;
            clear_mem();
            mem[0] = ins(op, 16'h050);
            mem[1] = ins(1, 16'h060);
            mem[16'h60] = 16'h1357;
            run_prog(cyc);
            check(cyc == 1, "R9 halt cycles", cyc, 1);
            a0 = mem_addr;
            quiet = 1;
            repeat (20) begin
                @(posedge clk);
                #1;
                if (!halted || mem_rd || mem_wr || mem_addr != a0) quiet = 0;
            end
            check(quiet, "R9 frozen", quiet, 1);
            check(mem[16'h60] == 16'h1357, "R9 no write", mem[16'h60], 16'h1357);
        end

        check(strobe_err == 0, "R11 strobes", strobe_err, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule